// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a memory-mapped event timer. It holds one 64-bit main counter that advances by one on each clock while software has it running. Next to the counter sits a row of compare channels. Each channel watches the counter and signals an event when the counter equals the channel's compare value. A channel can fire once (one-shot) or reload itself and fire again and again (periodic). It reports the event either as a single-cycle pulse or as a level that stays high until software clears it.

The number of channels is fixed when the block is elaborated and is limited to the range 3 to 32. The capability word reports the number actually built, so driver software can find it at run time. Software reaches everything through one simple port. A write takes one cycle. A read returns its data one cycle after the request, marked by a valid strobe. Accesses to channel slots beyond the built count do nothing.

Top module: `evt_timer`

## Requirements
- R1: The parameter CHANNELS is clamped to the range 3..32: a value below 3 builds 3 channels and a value above 32 builds 32.
- R2: The capability word at offset 0x000 reads as follows. Bits 7:0 = 0x01 (revision). Bits 12:8 = built channel count minus one. Bit 13 = 1 (64-bit counter). Bit 14 = 0. Bit 15 = 1 (legacy route capable). Bits 31:16 = VENDOR_ID. Bits 63:32 = TICK_FS, which defaults to 10,000,000 (10 ns per tick).
- R3: The register offsets are: general config 0x010, status 0x020, main counter 0x0F0. Channel n has its config at 0x100 + 0x20·n and its comparator at 0x100 + 0x20·n + 0x08. A read with rd_en returns data on rd_data with rd_valid high one clock later.
- R4: Only bits 1:0 of general config can be written. Bit 0 is run and bit 1 is the legacy-route flag, which is stored only. All other bits read as zero.
- R5: While run is 1, the counter adds one per clock. While run is 0, it holds its value. A write to the counter takes effect only while run is 0.
- R6: When run goes from 0 to 1, every channel whose comparator is not all-ones is armed. A comparator write while run is 1 arms that channel, unless the value written is all-ones. Clearing run disarms every channel.
- R7: Channel config bit 1 = level mode, bit 2 = interrupt enable, bit 3 = periodic. Other bits read as zero. When an armed channel n has counter == comparator and its interrupt enable is set, status bit n becomes 1. With interrupt enable clear, the match leaves status and irq untouched.
- R8: In edge mode (bit 1 = 0), irq[n] is high for exactly one clock per match. In level mode, irq[n] equals status bit n.
- R9: Writing the status register clears each status bit written as one. Bits written as zero are kept.
- R10: Writing a comparator also stores that value as the channel's period. On a match in periodic mode, the period is added to the comparator and the channel stays armed. On a match in one-shot mode, the channel disarms and its comparator is left unchanged.
- R11: A channel slot whose index is at or beyond the built count reads as zero. Writes to that slot change no state.
- R12: After reset, the counter, general config, status and every channel config are zero, and every comparator is all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for addr/wr_data |
| rd_en | input | 1 | Read request for addr |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |
| rd_data | output | 64 | Read data |
| irq | output | 32 | Per-channel interrupt. Bits at or above the channel count are zero |

## Verification
The assertions assume that wr_en and rd_en are never high together. They also assume that register writes are whole 64-bit words at offsets 8-byte aligned. The bench meets both: each access goes through a task that raises one strobe for one cycle. The periodic-reload and one-shot properties assume that no comparator write lands in the same cycle as a match. The bench therefore writes comparators only while the counter is halted, or far from any compare value. Run-time windows are chosen so that the final counter value falls well clear of every expected match. This makes pulse counts and reloaded comparators independent of the exact halt cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam int unsigned MIN_CH = 3;
   localparam int unsigned MAX_CH = 32;

   localparam logic [11:0] OFS_CAP   = 12'h000;
   localparam logic [11:0] OFS_GCFG  = 12'h010;
   localparam logic [11:0] OFS_STAT  = 12'h020;
   localparam logic [11:0] OFS_CNT   = 12'h0F0;
   localparam logic [11:0] OFS_CHAN  = 12'h100;

   localparam int unsigned CH_STRIDE_LOG2 = 5;
   localparam logic [4:0]  SUB_CFG = 5'h00;
   localparam logic [4:0]  SUB_CMP = 5'h08;

   typedef struct packed {
      logic periodic;
      logic int_en;
      logic level;
   } ch_cfg_t;

   function automatic int unsigned clamp_ch(input int unsigned n);
      if (n < MIN_CH) return MIN_CH;
      if (n > MAX_CH) return MAX_CH;
      return n;
   endfunction

   function automatic logic [63:0] cap_word(input int unsigned n,
                                            input logic [15:0] vid,
                                            input logic [31:0] fs);
      logic [4:0] cnt_m1;
      cnt_m1 = 5'(n - 1);
      return {fs, vid, 1'b1, 1'b0, 1'b1, cnt_m1, 8'h01};
   endfunction

endpackage

// File: rtl/evt_tick_counter.sv
module evt_tick_counter #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (run)      count <= count + WIDTH'(1);
      else if (load)     count <= load_val;
   end

   // R5: a halted counter with no load pending keeps its value
   assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> (count == $past(count)));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
   import evt_timer_pkg::*;
#(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             arm_all,
   input  logic             disarm_all,
   input  logic             cfg_wr,
   input  logic             cmp_wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] count,
   output ch_cfg_t          cfg,
   output logic [WIDTH-1:0] cmp,
   output logic             hit
);

   logic [WIDTH-1:0] period;
   logic             armed;

   assign hit = armed && (count == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         cmp    <= '1;
         period <= '0;
      end else begin
         if (cfg_wr) cfg <= '{periodic: wdata[3], int_en: wdata[2], level: wdata[1]};
         if (cmp_wr) begin
            cmp    <= wdata;
            period <= wdata;
         end else if (hit && cfg.periodic) begin
            cmp <= cmp + period;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (disarm_all)         armed <= 1'b0;
      else if (arm_all)            armed <= (cmp != '1);
      else if (cmp_wr && run)      armed <= (wdata != '1);
      else if (hit && !cfg.periodic) armed <= 1'b0;
   end

   // R10: a one-shot match leaves the channel disarmed
   assert_oneshot_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cfg.periodic && !cmp_wr && !arm_all) |=> !armed);

   // R10: a periodic match advances the comparator by the stored period
   assert_periodic_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cfg.periodic && !cmp_wr) |=> (cmp == $past(cmp + period)));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned CHANNELS  = 3,
   parameter int unsigned ADDR_W    = 12,
   parameter logic [15:0] VENDOR_ID = 16'h5A17,
   parameter logic [31:0] TICK_FS   = 32'd10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wr_data,
   output logic              rd_valid,
   output logic [63:0]       rd_data,
   output logic [31:0]       irq
);

   localparam int unsigned NCH   = clamp_ch(CHANNELS);
   localparam int unsigned IDX_W = ADDR_W - CH_STRIDE_LOG2;
   localparam logic [63:0] CAP   = cap_word(NCH, VENDOR_ID, TICK_FS);

   if (ADDR_W < 12 || ADDR_W > 16) begin : g_bad_addr_w
      $error("evt_timer: ADDR_W must lie in 12..16");
   end

   // ---------------- address decode ----------------
   logic              in_ch_space, ch_in_range;
   logic [ADDR_W-1:0] ch_off;
   logic [IDX_W-1:0]  ch_idx;
   logic [4:0]        ch_sub;
   logic              gcfg_wr, stat_wr, cnt_wr;

   assign in_ch_space = (addr >= ADDR_W'(OFS_CHAN));
   assign ch_off      = addr - ADDR_W'(OFS_CHAN);
   assign ch_idx      = ch_off[ADDR_W-1:CH_STRIDE_LOG2];
   assign ch_sub      = ch_off[CH_STRIDE_LOG2-1:0];
   assign ch_in_range = in_ch_space && (32'(ch_idx) < NCH);

   assign gcfg_wr = wr_en && (addr == ADDR_W'(OFS_GCFG));
   assign stat_wr = wr_en && (addr == ADDR_W'(OFS_STAT));
   assign cnt_wr  = wr_en && (addr == ADDR_W'(OFS_CNT));

   // ---------------- general configuration ----------------
   logic [1:0] gcfg_q;
   logic       en_rise, en_fall;

   assign en_rise = gcfg_wr &&  wr_data[0] && !gcfg_q[0];
   assign en_fall = gcfg_wr && !wr_data[0] &&  gcfg_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gcfg_q <= '0;
      else if (gcfg_wr) gcfg_q <= wr_data[1:0];
   end

   // ---------------- main counter ----------------
   logic [63:0] count;

   evt_tick_counter #(.WIDTH(64)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (gcfg_q[0]),
      .load     (cnt_wr),
      .load_val (wr_data),
      .count    (count)
   );

   // ---------------- channels ----------------
   ch_cfg_t     cfg_arr [NCH];
   logic [63:0] cmp_arr [NCH];
   logic [NCH-1:0] hit_v, inten_v, level_v;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = ch_in_range && (ch_idx == IDX_W'(i));

      evt_channel #(.WIDTH(64)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (gcfg_q[0]),
         .arm_all    (en_rise),
         .disarm_all (en_fall),
         .cfg_wr     (wr_en && sel && (ch_sub == SUB_CFG)),
         .cmp_wr     (wr_en && sel && (ch_sub == SUB_CMP)),
         .wdata      (wr_data),
         .count      (count),
         .cfg        (cfg_arr[i]),
         .cmp        (cmp_arr[i]),
         .hit        (hit_v[i])
      );

      assign inten_v[i] = cfg_arr[i].int_en;
      assign level_v[i] = cfg_arr[i].level;
   end

   // ---------------- status and interrupts ----------------
   logic [NCH-1:0] status_q, pulse_q, hit_ie, clr_mask;

   assign hit_ie   = hit_v & inten_v;
   assign clr_mask = stat_wr ? wr_data[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         pulse_q  <= '0;
      end else begin
         status_q <= (status_q & ~clr_mask) | hit_ie;
         pulse_q  <= hit_ie & ~level_v;
      end
   end

   if (NCH < 32) begin : g_irq_pad
      assign irq = {{(32 - NCH){1'b0}}, pulse_q | (status_q & level_v)};
   end else begin : g_irq_full
      assign irq = pulse_q | (status_q & level_v);
   end

   // ---------------- read path ----------------
   logic [63:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_W'(OFS_CAP))       rd_mux = CAP;
      else if (addr == ADDR_W'(OFS_GCFG)) rd_mux = 64'(gcfg_q);
      else if (addr == ADDR_W'(OFS_STAT)) rd_mux = 64'(status_q);
      else if (addr == ADDR_W'(OFS_CNT))  rd_mux = count;
      else if (ch_in_range) begin
         for (int i = 0; i < NCH; i++) begin
            if (ch_idx == IDX_W'(i)) begin
               if (ch_sub == SUB_CFG)      rd_mux = {60'd0, cfg_arr[i], 1'b0};
               else if (ch_sub == SUB_CMP) rd_mux = cmp_arr[i];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_mux;
      end
   end

   // R11: a read of an unbuilt channel slot returns zero
   assert_oor_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_ch_space && !ch_in_range) |=> (rd_data == '0));

   // R9: bits written as one are clear after the write unless a match set them again
   assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && (hit_ie == '0)) |=> ((status_q & $past(wr_data[NCH-1:0])) == '0));

   // R4: the legacy flag alone never starts the counter
   assert_run_bit_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gcfg_q[0] && !cnt_wr) |=> (count == $past(count)));

endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [63:0] wr_data = '0;
   logic        rd_valid, rd_valid_lo, rd_valid_hi;
   logic [63:0] rd_data, rd_data_lo, rd_data_hi;
   logic [31:0] irq, irq_lo, irq_hi;

   always #5 clk = ~clk;

   evt_timer #(.CHANNELS(3)) i_evt_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

   evt_timer #(.CHANNELS(1)) i_evt_timer_lo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_valid(rd_valid_lo), .rd_data(rd_data_lo), .irq(irq_lo));

   evt_timer #(.CHANNELS(40)) i_evt_timer_hi (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_valid(rd_valid_hi), .rd_data(rd_data_hi), .irq(irq_hi));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] exp_q[$];
   string       tag_q[$];

   int pulses0 = 0;
   int pulses2 = 0;

   localparam logic [63:0] ONES = '1;

   function automatic logic [63:0] cap_exp(input int n);
      logic [4:0] m;
      m = 5'(n - 1);
      return {32'd10_000_000, 16'h5A17, 1'b1, 1'b0, 1'b1, m, 8'h01};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // scoreboard driver: queue the expectation, then issue the read
   task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual=%h expected=<none>", rd_data);
         end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rd_data, e);
         end
      end
      if (irq[0]) pulses0++;
      if (irq[2]) pulses2++;
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      int base0, base2;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R12 reset state, R2/R3 capability and offsets
      check("R12 irq after reset", 64'(irq), 64'd0);
      rd(12'h000, cap_exp(3), "R2 capability word");
      check("R1 clamp low (1->3)", rd_data_lo, cap_exp(3));
      check("R1 clamp high (40->32)", rd_data_hi, cap_exp(32));
      rd(12'h010, 64'd0, "R12 general config reset");
      rd(12'h020, 64'd0, "R12 status reset");
      rd(12'h0F0, 64'd0, "R12 counter reset");
      rd(12'h108, ONES, "R12 comparator ch0 reset");
      rd(12'h148, ONES, "R12 comparator ch2 reset");
      rd(12'h140, 64'd0, "R12 channel config ch2 reset");

      // R4 writable bits of general config
      wr(12'h010, 64'hFFFF_FFFF_FFFF_FFFC);
      rd(12'h010, 64'd0, "R4 reserved bits read zero");
      wr(12'h010, 64'h2);
      rd(12'h010, 64'h2, "R4 legacy flag stored");
      rd(12'h0F0, 64'd0, "R4 legacy flag does not run counter");
      wr(12'h010, 64'h0);

      // R5 counter run/halt/load
      wr(12'h0F0, 64'd1000);
      rd(12'h0F0, 64'd1000, "R5 load while halted");
      wr(12'h010, 64'h1);
      wr(12'h010, 64'h0);
      rd(12'h0F0, 64'd1002, "R5 two ticks between run and halt");
      idle(20);
      rd(12'h0F0, 64'd1002, "R5 halted counter holds");
      wr(12'h010, 64'h1);
      wr(12'h0F0, 64'd5);
      wr(12'h010, 64'h0);
      rd(12'h0F0, 64'd1006, "R5 load ignored while running");

      // R7/R8/R10 one-shot matches, edge and level, int enable
      wr(12'h0F0, 64'd0);
      wr(12'h100, 64'h4);   // ch0: int enable, edge, one-shot
      wr(12'h108, 64'd50);
      wr(12'h120, 64'h6);   // ch1: int enable, level
      wr(12'h128, 64'd60);
      wr(12'h140, 64'h0);   // ch2: int disabled
      wr(12'h148, 64'd30);
      rd(12'h120, 64'h6, "R7 config field positions");
      base0 = pulses0; base2 = pulses2;
      wr(12'h010, 64'h1);   // R6 arming on run rise
      idle(120);
      wr(12'h010, 64'h0);
      check("R8 edge pulse count one-shot", 64'(pulses0 - base0), 64'd1);
      check("R7 no irq with int disabled", 64'(pulses2 - base2), 64'd0);
      rd(12'h020, 64'h3, "R7 status bits set by matches");
      rd(12'h108, 64'd50, "R10 one-shot comparator unchanged");
      check("R8 level irq held", 64'(irq[1]), 64'd1);
      check("R8 edge irq returns low", 64'(irq[0]), 64'd0);

      // R9 write-one-to-clear
      wr(12'h020, 64'h1);
      rd(12'h020, 64'h2, "R9 clear bit0 keeps bit1");
      check("R9 level irq stays with status", 64'(irq[1]), 64'd1);
      wr(12'h020, 64'h2);
      rd(12'h020, 64'h0, "R9 clear bit1");
      check("R8 level irq drops after clear", 64'(irq[1]), 64'd0);

      // R10 periodic reload
      wr(12'h0F0, 64'd0);
      wr(12'h100, 64'hC);   // ch0: periodic, int enable, edge
      wr(12'h108, 64'd40);
      base0 = pulses0;
      wr(12'h010, 64'h1);
      idle(130);
      wr(12'h010, 64'h0);
      check("R10 periodic fires three times", 64'(pulses0 - base0), 64'd3);
      rd(12'h108, 64'd160, "R10 comparator advanced by period");
      wr(12'h020, 64'h7);

      // R6 arming by comparator write while running, all-ones not armed
      wr(12'h0F0, 64'd0);
      wr(12'h100, 64'h4);
      wr(12'h108, ONES);
      base0 = pulses0;
      wr(12'h010, 64'h1);
      idle(10);
      check("R6 all-ones comparator stays quiet", 64'(pulses0 - base0), 64'd0);
      wr(12'h108, 64'd80);
      idle(120);
      wr(12'h010, 64'h0);
      check("R6 comparator write while running arms", 64'(pulses0 - base0), 64'd1);
      wr(12'h020, 64'h7);

      // R11 unbuilt channel slot
      wr(12'h160, 64'hE);
      wr(12'h168, 64'd5);
      rd(12'h160, 64'd0, "R11 unbuilt config reads zero");
      rd(12'h168, 64'd0, "R11 unbuilt comparator reads zero");
      rd(12'h108, 64'd80, "R11 ch0 comparator untouched");
      rd(12'h128, 64'd60, "R11 ch1 comparator untouched");
      rd(12'h148, 64'd30, "R11 ch2 comparator untouched");
      rd(12'h020, 64'd0, "R11 status untouched");
      check("R11 irq quiet", 64'(irq), 64'd0);

      idle(4);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end
      done = 1'b1;
      finish_run();
   end

endmodule